// File: doc/BRIEF.md
# Endian-Selectable Byte FIFO Port

This block is a four-byte shift store that sits between a 16-bit register data port and a serial transfer engine. Software writes transmit data either as a 16-bit word, which shifts two bytes in, or as a single byte. The engine then pulls bytes out one at a time, and the oldest byte leaves first. In the receive direction the engine deposits bytes into the next free lane, and a register read takes up to two of them at once. A byte-order input sets which byte of a 16-bit access maps to the lower lane. The transmit and receive sides share the four lanes but keep separate byte counts.

The block keeps the status flags that depend on the store: transmit underflow, receive overrun, transmit ready, receive ready and a flag for a read that found a single byte. It also issues a one-cycle completion pulse when a read drains a master receive transfer. Only one operation is served per cycle. A register write comes first, then a register read, then an engine pull, then an engine push. Any lower-ranked request in the same cycle is dropped.

Top module: `fifo_port`

## Requirements
- R1: After reset both byte counts are 0, every flag and the completion pulse are 0, and all four lanes hold 0.
- R2: An accepted 16-bit write shifts the lanes up by two (lane i takes lane i-2) and adds 2 to the transmit count. With `bigEndian`=1, `wrData[15:8]` goes to lane 1 and `wrData[7:0]` to lane 0. With `bigEndian`=0 the two bytes are swapped.
- R3: An accepted byte write (`wrByte`=1) shifts the lanes up by one, puts `wrData[7:0]` in lane 0 and adds 1 to the transmit count.
- R4: A write of either width while the transmit count is above 2 is refused. The lanes, the counts and the flags stay as they were.
- R5: An accepted write clears `txUnderflow`, and it clears `txReady` when the new transmit count is above 2.
- R6: `txByte` shows lane (transmit count − 1). A pull with a nonzero count decrements the count, and it sets `txReady` when 2 or fewer bytes remain. A pull with a count of 0 sets `txUnderflow` and changes nothing else.
- R7: `rdData` shows lanes 0 and 1 combinationally. With `bigEndian`=1, lane 0 is on bits 15:8 and lane 1 on bits 7:0. With `bigEndian`=0, lane 1 is on bits 15:8 and lane 0 on bits 7:0.
- R8: A read with a receive count of 1 sets `singleByte` and sets the receive count to 0.
- R9: A read with a receive count above 1 subtracts 2 from it. The lanes shift down by two (lane i takes lane i+2, zero fill) only if the count was above 2.
- R10: Every read clears `rxOverrun`. A read that leaves the receive count at 0 clears `rxReady`. If `modeMaster`=1 and `modeTransmit`=0, it also raises `accessDone` for exactly one cycle.
- R11: An engine push with a receive count below 4 writes `rxByte` into the lane given by the count, increments the count, sets `rxReady` and clears `singleByte`. With a count of 4 the push is dropped and `rxOverrun` is set.
- R12: A read with a receive count of 0 leaves both counts and the lanes unchanged.
- R13: Priority is write, then read, then pull, then push. A lower-ranked request in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | Byte order of 16-bit accesses |
| modeMaster | input | 1 | Transfer engine is in master mode |
| modeTransmit | input | 1 | Transfer direction is transmit |
| wrEn | input | 1 | Register data write |
| wrByte | input | 1 | Write is one byte wide (else 16-bit) |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Register data read (pops on the clock edge) |
| rdData | output | 16 | Read data, lanes 0 and 1 |
| txPop | input | 1 | Engine pulls one transmit byte |
| txByte | output | 8 | Byte the next pull takes |
| txCount | output | 3 | Transmit bytes pending |
| rxPush | input | 1 | Engine deposits one received byte |
| rxByte | input | 8 | Received byte |
| rxCount | output | 3 | Received bytes pending |
| txReady | output | 1 | Transmit ready flag |
| rxReady | output | 1 | Receive ready flag |
| txUnderflow | output | 1 | Transmit underflow flag |
| rxOverrun | output | 1 | Receive overrun flag |
| singleByte | output | 1 | Last read found a single byte |
| accessDone | output | 1 | One-cycle pulse: master receive drained |

## Verification
The hardest states to reach are those where the two directions share lanes that an earlier operation left filled. Examples are a refused write that lands on three pending bytes, and a read that holds exactly two bytes, where the lanes must not shift. The bench reaches them by chaining operations without a reset between them, so leftover lanes from the transmit side become the background for the receive side. Each lane that survives is then read back through `rdData` or pulled out through `txByte`. Priority is exercised by raising all four requests in one cycle and watching which count moves.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;
  localparam int LANES      = 4;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int CNT_W      = $clog2(LANES + 1);

  typedef struct packed {
    logic                  push16;    // shift up two lanes, load word
    logic                  push8;     // shift up one lane, load byte
    logic                  drop16;    // shift down two lanes, zero fill
    logic                  load;      // write rxByte into loadLane
    logic [LANE_IDX_W-1:0] loadLane;
    logic [LANE_IDX_W-1:0] popLane;
  } dpStrobe_t;
endpackage

// File: rtl/fifo_port_datapath.sv
module fifo_port_datapath
  import fifo_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              bigEndian,
  input  logic [WORD_W-1:0] wrData,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [WORD_W-1:0] rdData,
  output logic [BYTE_W-1:0] txByte
);
  logic [BYTE_W-1:0] lane [LANES];
  logic [BYTE_W-1:0] hiIn, loIn;

  assign hiIn = bigEndian ? wrData[WORD_W-1:BYTE_W] : wrData[BYTE_W-1:0];
  assign loIn = bigEndian ? wrData[BYTE_W-1:0]      : wrData[WORD_W-1:BYTE_W];

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [BYTE_W-1:0] upTwo, upOne, downTwo;
    if (i >= 2) begin : gUp2
      assign upTwo = lane[i-2];
    end else if (i == 1) begin : gHi
      assign upTwo = hiIn;
    end else begin : gLo
      assign upTwo = loIn;
    end
    if (i >= 1) begin : gUp1
      assign upOne = lane[i-1];
    end else begin : gIn1
      assign upOne = wrData[BYTE_W-1:0];
    end
    if (i + 2 < LANES) begin : gDn2
      assign downTwo = lane[i+2];
    end else begin : gZero
      assign downTwo = '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                    lane[i] <= '0;
      else if (strobe.push16)                       lane[i] <= upTwo;
      else if (strobe.push8)                        lane[i] <= upOne;
      else if (strobe.drop16)                       lane[i] <= downTwo;
      else if (strobe.load && strobe.loadLane == i) lane[i] <= rxByte;
    end

    if (i >= 2) begin : gChkUp
      assert_wide_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
        strobe.push16 |=> lane[i] == $past(lane[i-2]));
    end
    if (i + 2 < LANES) begin : gChkDn
      assert_read_shift_R9: assert property (@(posedge clk) disable iff (!rstN)
        strobe.drop16 |=> lane[i] == $past(lane[i+2]));
    end
  end

  assign rdData = bigEndian ? {lane[0], lane[1]} : {lane[1], lane[0]};
  assign txByte = lane[strobe.popLane];
endmodule

// File: rtl/fifo_port_ctrl.sv
module fifo_port_ctrl
  import fifo_port_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeMaster,
  input  logic             modeTransmit,
  input  logic             wrEn,
  input  logic             wrByte,
  input  logic             rdEn,
  input  logic             txPop,
  input  logic             rxPush,
  output dpStrobe_t        strobe,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txReady,
  output logic             rxReady,
  output logic             txUnderflow,
  output logic             rxOverrun,
  output logic             singleByte,
  output logic             accessDone
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LANES);

  logic             doWr, doRd, doPop, doPush, wrOk;
  logic [CNT_W-1:0] txAfterWr, rxAfterRd;

  // fixed priority: write, read, pull, push (R13)
  assign doWr   = wrEn;
  assign doRd   = rdEn && !wrEn;
  assign doPop  = txPop && !wrEn && !rdEn;
  assign doPush = rxPush && !wrEn && !rdEn && !txPop;

  assign wrOk      = doWr && (txCount <= TWO);
  assign txAfterWr = txCount + (wrByte ? ONE : TWO);
  assign rxAfterRd = (rxCount > ONE) ? rxCount - TWO : '0;

  always_comb begin
    strobe          = '0;
    strobe.push16   = wrOk && !wrByte;
    strobe.push8    = wrOk && wrByte;
    strobe.drop16   = doRd && (rxCount > TWO);
    strobe.load     = doPush && (rxCount < FULL);
    strobe.loadLane = rxCount[LANE_IDX_W-1:0];
    strobe.popLane  = txCount[LANE_IDX_W-1:0] - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCount     <= '0;
      rxCount     <= '0;
      txReady     <= 1'b0;
      rxReady     <= 1'b0;
      txUnderflow <= 1'b0;
      rxOverrun   <= 1'b0;
      singleByte  <= 1'b0;
      accessDone  <= 1'b0;
    end else begin
      accessDone <= 1'b0;
      if (wrOk) begin
        txCount     <= txAfterWr;
        txUnderflow <= 1'b0;
        if (txAfterWr > TWO) txReady <= 1'b0;
      end else if (doRd) begin
        rxOverrun <= 1'b0;
        rxCount   <= rxAfterRd;
        if (rxCount == ONE) singleByte <= 1'b1;
        if (rxAfterRd == '0) begin
          rxReady <= 1'b0;
          if (modeMaster && !modeTransmit) accessDone <= 1'b1;
        end
      end else if (doPop) begin
        if (txCount != '0) begin
          txCount <= txCount - ONE;
          if (txCount - ONE <= TWO) txReady <= 1'b1;
        end else begin
          txUnderflow <= 1'b1;
        end
      end else if (doPush) begin
        if (rxCount < FULL) begin
          rxCount    <= rxCount + ONE;
          rxReady    <= 1'b1;
          singleByte <= 1'b0;
        end else begin
          rxOverrun <= 1'b1;
        end
      end
    end
  end

  assert_refuse_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txCount > TWO) |=> (txCount == $past(txCount)));
  assert_udf_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && txCount <= TWO) |=> !txUnderflow);
  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && rxCount == ONE) |=> (singleByte && rxCount == '0));
  assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |=> !rxOverrun);
  assert_bounds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= FULL) && (rxCount <= FULL));
  assert_write_wins_R13: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rxCount == $past(rxCount)));
endmodule

// File: rtl/fifo_port.sv
module fifo_port
  import fifo_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic              modeMaster,
  input  logic              modeTransmit,
  input  logic              wrEn,
  input  logic              wrByte,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  input  logic              txPop,
  output logic [BYTE_W-1:0] txByte,
  output logic [CNT_W-1:0]  txCount,
  input  logic              rxPush,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txReady,
  output logic              rxReady,
  output logic              txUnderflow,
  output logic              rxOverrun,
  output logic              singleByte,
  output logic              accessDone
);
  dpStrobe_t strobe;

  fifo_port_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .modeMaster(modeMaster), .modeTransmit(modeTransmit),
    .wrEn(wrEn), .wrByte(wrByte), .rdEn(rdEn), .txPop(txPop), .rxPush(rxPush),
    .strobe(strobe), .txCount(txCount), .rxCount(rxCount), .txReady(txReady),
    .rxReady(rxReady), .txUnderflow(txUnderflow), .rxOverrun(rxOverrun),
    .singleByte(singleByte), .accessDone(accessDone)
  );

  fifo_port_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bigEndian(bigEndian),
    .wrData(wrData), .rxByte(rxByte), .rdData(rdData), .txByte(txByte)
  );
endmodule

// File: tb/tb_fifo_port.sv
module tb_fifo_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bigEndian = 1'b0, modeMaster = 1'b0, modeTransmit = 1'b0;
  logic wrEn = 1'b0, wrByte = 1'b0, rdEn = 1'b0, txPop = 1'b0, rxPush = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  rxByte = '0;
  logic [15:0] rdData;
  logic [7:0]  txByte;
  logic [2:0]  txCount, rxCount;
  logic txReady, rxReady, txUnderflow, rxOverrun, singleByte, accessDone;

  int nRun = 0, nFail = 0;
  logic [15:0] obs;

  always #5 clk = ~clk;

  fifo_port dut (.*);

  localparam logic [2:0] OP_W16 = 3'd1, OP_W8 = 3'd2, OP_RD = 3'd3,
                         OP_POP = 3'd4, OP_PUSH = 3'd5;
  localparam int NV = 14;
  // {op, bigEndian, data, expected observation, expected txCount, expected rxCount}
  localparam logic [41:0] VEC [NV] = '{
    {OP_W16,  1'b1, 16'hA1B2, 16'h0000, 3'd2, 3'd0},  // R2 big-endian lanes
    {OP_POP,  1'b0, 16'h0000, 16'h00A1, 3'd1, 3'd0},  // R6
    {OP_POP,  1'b0, 16'h0000, 16'h00B2, 3'd0, 3'd0},
    {OP_W16,  1'b0, 16'h1234, 16'h0000, 3'd2, 3'd0},  // R2 swapped lanes
    {OP_W8,   1'b0, 16'h0056, 16'h0000, 3'd3, 3'd0},  // R3
    {OP_W16,  1'b1, 16'hFFFF, 16'h0000, 3'd3, 3'd0},  // R4 refused
    {OP_POP,  1'b0, 16'h0000, 16'h0034, 3'd2, 3'd0},
    {OP_POP,  1'b0, 16'h0000, 16'h0012, 3'd1, 3'd0},
    {OP_POP,  1'b0, 16'h0000, 16'h0056, 3'd0, 3'd0},
    {OP_PUSH, 1'b0, 16'h0011, 16'h0000, 3'd0, 3'd1},  // R11
    {OP_PUSH, 1'b0, 16'h0022, 16'h0000, 3'd0, 3'd2},
    {OP_PUSH, 1'b0, 16'h0033, 16'h0000, 3'd0, 3'd3},
    {OP_RD,   1'b0, 16'h0000, 16'h2211, 3'd0, 3'd1},  // R7 R9 shift
    {OP_RD,   1'b1, 16'h0000, 16'h33B2, 3'd0, 3'd0}   // R7 R8
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one operation, capture the pre-edge observation, let the edge pass
  task automatic doOp(input logic [2:0] op, input logic be, input logic [15:0] d,
                      output logic [15:0] seen);
    @(negedge clk);
    bigEndian = be;
    wrEn   = (op == OP_W16) || (op == OP_W8);
    wrByte = (op == OP_W8);
    wrData = d;
    rdEn   = (op == OP_RD);
    txPop  = (op == OP_POP);
    rxPush = (op == OP_PUSH);
    rxByte = d[7:0];
    #1;
    seen = (op == OP_RD) ? rdData : {8'h00, txByte};
    @(posedge clk);
    #1;
    wrEn = 0; wrByte = 0; rdEn = 0; txPop = 0; rxPush = 0;
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txCount == 0 && rxCount == 0, "R1 counts", {txCount, rxCount}, 0);
    check({txReady, rxReady, txUnderflow, rxOverrun, singleByte, accessDone} == 0,
          "R1 flags", {txReady, rxReady, txUnderflow, rxOverrun, singleByte, accessDone}, 0);
    check(rdData == 16'h0000, "R1 lanes", rdData, 0);

    for (int k = 0; k < NV; k++) begin
      logic [41:0] v;
      v = VEC[k];
      doOp(v[41:39], v[38], v[37:22], obs);
      if (v[41:39] == OP_RD || v[41:39] == OP_POP)
        check(obs == v[21:6], $sformatf("R7/R6 vector %0d data", k), obs, v[21:6]);
      check(txCount == v[5:3] && rxCount == v[2:0],
            $sformatf("R2/R3/R4/R9/R11 vector %0d counts", k), {txCount, rxCount}, v[5:0]);
    end
    check(singleByte == 1'b1, "R8 single flag", singleByte, 1);
    check(rxReady == 1'b0, "R10 rxReady cleared", rxReady, 0);

    // R6 underflow on empty pull
    doOp(OP_POP, 0, 0, obs);
    check(txUnderflow == 1 && txCount == 0, "R6 underflow", {txUnderflow, txCount}, 8);
    // R5 write clears underflow, ready tracking
    doOp(OP_W8, 0, 16'h0077, obs);
    check(txUnderflow == 0 && txCount == 1, "R5 underflow cleared", {txUnderflow, txCount}, 1);
    doOp(OP_W16, 1, 16'h8899, obs);
    check(txReady == 0 && txCount == 3, "R5 ready low at 3", {txReady, txCount}, 3);
    doOp(OP_POP, 0, 0, obs);
    check(obs[7:0] == 8'h77 && txReady == 1, "R6 pull sets ready", {txReady, obs[7:0]}, 9'h177);
    doOp(OP_W8, 0, 16'h00AA, obs);
    check(txReady == 0 && txCount == 3, "R5 ready cleared", {txReady, txCount}, 3);
    doOp(OP_W8, 0, 16'h00BB, obs);  // refused byte write
    check(txCount == 3, "R4 byte write refused count", txCount, 3);
    doOp(OP_POP, 0, 0, obs);
    check(obs[7:0] == 8'h88, "R4 lanes unchanged", obs[7:0], 8'h88);
    doOp(OP_POP, 0, 0, obs);
    check(obs[7:0] == 8'h99, "R6 pull lane1", obs[7:0], 8'h99);
    doOp(OP_POP, 0, 0, obs);
    check(obs[7:0] == 8'hAA && txCount == 0, "R6 pull lane0", obs[7:0], 8'hAA);

    // R11 receive fill, overrun, singleByte clear
    doOp(OP_PUSH, 0, 16'h0001, obs);
    check(singleByte == 0 && rxReady == 1 && rxCount == 1, "R11 push flags",
          {singleByte, rxReady, rxCount}, 5'b01001);
    doOp(OP_PUSH, 0, 16'h0002, obs);
    doOp(OP_PUSH, 0, 16'h0003, obs);
    doOp(OP_PUSH, 0, 16'h0004, obs);
    check(rxCount == 4 && rxOverrun == 0, "R11 full", {rxOverrun, rxCount}, 4);
    doOp(OP_PUSH, 0, 16'h0005, obs);
    check(rxCount == 4 && rxOverrun == 1, "R11 overrun", {rxOverrun, rxCount}, 12);
    doOp(OP_RD, 0, 0, obs);
    check(obs == 16'h0201 && rxCount == 2 && rxOverrun == 0, "R10 read clears overrun",
          {rxOverrun, rxCount, obs}, {1'b0, 3'd2, 16'h0201});
    modeMaster = 1; modeTransmit = 0;
    doOp(OP_RD, 0, 0, obs);
    check(obs == 16'h0403 && rxCount == 0, "R9 read of two", {rxCount, obs}, 16'h0403);
    check(accessDone == 1 && rxReady == 0, "R10 accessDone pulse", {accessDone, rxReady}, 2);
    modeMaster = 0;
    doOp(OP_RD, 1, 0, obs);
    check(accessDone == 0, "R10 pulse one cycle", accessDone, 0);
    check(obs == 16'h0304 && rxCount == 0 && txCount == 0, "R12 empty read (R9 no shift)",
          {rxCount, txCount, obs}, 16'h0304);

    // R13 priority: all requests at once, write wins
    @(negedge clk);
    bigEndian = 1; wrEn = 1; wrByte = 0; wrData = 16'h5566;
    rdEn = 1; txPop = 1; rxPush = 1; rxByte = 8'h99;
    @(posedge clk); #1;
    wrEn = 0; rdEn = 0; txPop = 0; rxPush = 0;
    check(txCount == 2 && rxCount == 0, "R13 write wins", {txCount, rxCount}, 16);
    @(negedge clk);
    rdEn = 1; txPop = 1;
    @(posedge clk); #1;
    rdEn = 0; txPop = 0;
    check(txCount == 2, "R13 read beats pull", txCount, 2);
    doOp(OP_POP, 0, 0, obs);
    check(obs[7:0] == 8'h55 && txCount == 1, "R13 R2 lane1 after priority", obs[7:0], 8'h55);
    doOp(OP_POP, 0, 0, obs);
    check(obs[7:0] == 8'h66 && txCount == 0, "R2 lane0 after priority", obs[7:0], 8'h66);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule